// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Collision Arbitration

This block is a synchronous two-port RAM, with a left port and a right port. It watches for both ports selecting the same word at once. When that happens it picks one winner. The other port gets an active-low busy flag, and its writes are dropped for as long as the flag is held. Reads are never held back. A port that loses still reads the word as it stood before the winning write in that cycle.

The two ports are symmetric. Either port can win. Arbitration starts in one of two ways:
- both ports become enabled while their addresses already match, or
- the addresses come to match while both ports are already enabled.

When the flag is released, the losing port must wait a programmable number of extra cycles before a write can land.

A static mode input picks master or slave operation. In master mode the block computes the busy flags itself and drives them. In slave mode the flags come in from an outside master device, and they gate writes in the same way. In slave mode the busy outputs rest inactive.

Top module: `dpc_ram_top`

## Requirements
- R1: A collision is both chip enables high with equal addresses. This holds whether the enables rose on a matching address or the addresses came to match while both were already enabled. In master mode a collision drives the losing port's busy output low (active-low, 0 = busy).
- R2: At most one busy output is ever low. When neither port was enabled on its current address in the previous cycle, the left port wins and the right port is flagged.
- R3: A port that was already enabled on the same address in the previous cycle wins against a newcomer. The winner is kept for as long as the collision lasts, even if the winner's access changes from write to read.
- R4: Busy goes low in the same cycle as the collision. It stays low for exactly one cycle after the collision ends, then returns high.
- R5: While a port is busy, its write is suppressed and memory is unchanged. Its read still proceeds and returns the word held before that cycle's write.
- R6: After a port's busy is released, that port's writes stay suppressed for HOLD_CYC more cycles (default 2). The write in the next cycle after that lands.
- R7: In slave mode (master_i = 0), busy_x_ni = 0 suppresses that port's writes, with the same HOLD_CYC tail after release. Both busy outputs stay 1 even while the ports collide.
- R8: After reset, both busy outputs are 1, both read-data outputs are 0, and every memory word reads 0.
- R9: Read data is registered: it appears one clock after an enabled access and shows the old word when the same cycle writes that address. It holds while the port's chip enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = generate busy locally, 0 = take busy from inputs; static after reset |
| ce_l_i | input | 1 | Left chip enable, active high |
| we_l_i | input | 1 | Left write strobe (1 = write, 0 = read) |
| addr_l_i | input | ADDR_W | Left address |
| wdata_l_i | input | DATA_W | Left write data |
| rdata_l_o | output | DATA_W | Left registered read data |
| busy_l_ni | input | 1 | Left busy from an external master, active low (slave mode) |
| busy_l_no | output | 1 | Left busy flag, active low (master mode) |
| ce_r_i | input | 1 | Right chip enable, active high |
| we_r_i | input | 1 | Right write strobe (1 = write, 0 = read) |
| addr_r_i | input | ADDR_W | Right address |
| wdata_r_i | input | DATA_W | Right write data |
| rdata_r_o | output | DATA_W | Right registered read data |
| busy_r_ni | input | 1 | Right busy from an external master, active low (slave mode) |
| busy_r_no | output | 1 | Right busy flag, active low (master mode) |

## Verification
The assertions assume that master_i changes only while reset is held. They also assume that, in master mode, the block's own arbitration is the only source of busy. Outside busy inputs are ignored in that mode, so they can never make both ports write one word together.

The stimulus keeps to these limits:
- It sets the mode only inside a reset pulse.
- It changes every input on the falling edge, so each cycle presents one settled address and enable pattern to the arbiter.
- It holds the busy inputs inactive throughout every master-mode run.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_L    = 2'd1,
    OWN_R    = 2'd2
  } owner_e;

  localparam int unsigned NPORT = 2;
endpackage

// File: rtl/dpc_collide_arb.sv
module dpc_collide_arb
  import dpc_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_l_i,
  input  logic [ADDR_W-1:0] addr_l_i,
  input  logic              ce_r_i,
  input  logic [ADDR_W-1:0] addr_r_i,
  output logic              collide_o,
  output logic              busy_l_o,
  output logic              busy_r_o
);
  logic              ce_l_q, ce_r_q;
  logic [ADDR_W-1:0] addr_l_q, addr_r_q;
  owner_e            owner_q, owner_d, win;
  logic              est_l, est_r;

  // a port is "established" if it held the same address last cycle
  assign est_l     = ce_l_q && (addr_l_q == addr_l_i);
  assign est_r     = ce_r_q && (addr_r_q == addr_r_i);
  assign collide_o = ce_l_i && ce_r_i && (addr_l_i == addr_r_i);

  always_comb begin
    if (owner_q != OWN_NONE)   win = owner_q;
    else if (est_r && !est_l)  win = OWN_R;
    else                       win = OWN_L;
  end

  assign owner_d  = collide_o ? win : OWN_NONE;
  assign busy_l_o = collide_o ? (win == OWN_R) : (owner_q == OWN_R);
  assign busy_r_o = collide_o ? (win == OWN_L) : (owner_q == OWN_L);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_l_q   <= 1'b0;
      ce_r_q   <= 1'b0;
      addr_l_q <= '0;
      addr_r_q <= '0;
      owner_q  <= OWN_NONE;
    end else begin
      ce_l_q   <= ce_l_i;
      ce_r_q   <= ce_r_i;
      addr_l_q <= addr_l_i;
      addr_r_q <= addr_r_i;
      owner_q  <= owner_d;
    end
  end

  p_one_loser_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_l_o && busy_r_o));

  p_tie_left_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (collide_o && !$past(ce_l_i) && !$past(ce_r_i)) |-> busy_r_o);

  p_owner_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (collide_o && $past(collide_o)) |-> (busy_l_o == $past(busy_l_o)));

  p_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!collide_o && !$past(collide_o)) |-> (!busy_l_o && !busy_r_o));

  p_collide_flag_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collide_o |-> (busy_l_o || busy_r_o));
endmodule

// File: rtl/dpc_wr_hold.sv
module dpc_wr_hold #(
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic ce_i,
  input  logic we_i,
  output logic wr_en_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (busy_i)       cnt_q <= CW'(HOLD_CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign wr_en_o = ce_i && we_i && !busy_i && (cnt_q == '0);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_i) |-> !wr_en_o);

  p_busy_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !wr_en_o);
endmodule

// File: rtl/dpc_mem.sv
module dpc_mem #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_l_i,
  input  logic              wr_l_i,
  input  logic [ADDR_W-1:0] addr_l_i,
  input  logic [DATA_W-1:0] wdata_l_i,
  output logic [DATA_W-1:0] rdata_l_o,
  input  logic              ce_r_i,
  input  logic              wr_r_i,
  input  logic [ADDR_W-1:0] addr_r_i,
  input  logic [DATA_W-1:0] wdata_r_i,
  output logic [DATA_W-1:0] rdata_r_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      // right first so the left port takes priority on an unarbitrated clash
      if (wr_r_i) mem_q[addr_r_i] <= wdata_r_i;
      if (wr_l_i) mem_q[addr_l_i] <= wdata_l_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_l_o <= '0;
      rdata_r_o <= '0;
    end else begin
      if (ce_l_i) rdata_l_o <= mem_q[addr_l_i];
      if (ce_r_i) rdata_r_o <= mem_q[addr_r_i];
    end
  end

  p_rd_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_l_i |=> $stable(rdata_l_o));
endmodule

// File: rtl/dpc_ram_top.sv
module dpc_ram_top
  import dpc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              ce_l_i,
  input  logic              we_l_i,
  input  logic [ADDR_W-1:0] addr_l_i,
  input  logic [DATA_W-1:0] wdata_l_i,
  output logic [DATA_W-1:0] rdata_l_o,
  input  logic              busy_l_ni,
  output logic              busy_l_no,
  input  logic              ce_r_i,
  input  logic              we_r_i,
  input  logic [ADDR_W-1:0] addr_r_i,
  input  logic [DATA_W-1:0] wdata_r_i,
  output logic [DATA_W-1:0] rdata_r_o,
  input  logic              busy_r_ni,
  output logic              busy_r_no
);
  logic             collide;
  logic             arb_busy_l, arb_busy_r;
  logic [NPORT-1:0] arb_busy, ext_busy, eff_busy, ce_v, we_v, wr_en;

  dpc_collide_arb #(.ADDR_W(ADDR_W)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_l_i    (ce_l_i),
    .addr_l_i  (addr_l_i),
    .ce_r_i    (ce_r_i),
    .addr_r_i  (addr_r_i),
    .collide_o (collide),
    .busy_l_o  (arb_busy_l),
    .busy_r_o  (arb_busy_r)
  );

  assign arb_busy = {arb_busy_r, arb_busy_l};
  assign ext_busy = {~busy_r_ni, ~busy_l_ni};
  assign ce_v     = {ce_r_i, ce_l_i};
  assign we_v     = {we_r_i, we_l_i};
  assign eff_busy = master_i ? arb_busy : ext_busy;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpc_wr_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .busy_i  (eff_busy[p]),
      .ce_i    (ce_v[p]),
      .we_i    (we_v[p]),
      .wr_en_o (wr_en[p])
    );
  end

  assign busy_l_no = master_i ? ~arb_busy_l : 1'b1;
  assign busy_r_no = master_i ? ~arb_busy_r : 1'b1;

  dpc_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_l_i    (ce_l_i),
    .wr_l_i    (wr_en[0]),
    .addr_l_i  (addr_l_i),
    .wdata_l_i (wdata_l_i),
    .rdata_l_o (rdata_l_o),
    .ce_r_i    (ce_r_i),
    .wr_r_i    (wr_en[1]),
    .addr_r_i  (addr_r_i),
    .wdata_r_i (wdata_r_i),
    .rdata_r_o (rdata_r_o)
  );

  p_no_dual_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && collide) |-> !(wr_en[0] && wr_en[1]));

  p_mode_static_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(master_i));

  p_loser_flag_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && collide) |-> (busy_l_no ^ busy_r_no));
endmodule

// File: tb/dpc_ram_top_bench.sv
module dpc_ram_top_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        master = 1'b1;
  logic        ce_l = 0, we_l = 0, ce_r = 0, we_r = 0;
  logic [5:0]  addr_l = '0, addr_r = '0;
  logic [15:0] wd_l = '0, wd_r = '0;
  logic [15:0] rd_l, rd_r;
  logic        bin_l = 1'b1, bin_r = 1'b1;
  logic        bout_l, bout_r;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  dpc_ram_top u_dpc_ram_top (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master),
    .ce_l_i(ce_l), .we_l_i(we_l), .addr_l_i(addr_l), .wdata_l_i(wd_l),
    .rdata_l_o(rd_l), .busy_l_ni(bin_l), .busy_l_no(bout_l),
    .ce_r_i(ce_r), .we_r_i(we_r), .addr_r_i(addr_r), .wdata_r_i(wd_r),
    .rdata_r_o(rd_r), .busy_r_ni(bin_r), .busy_r_no(bout_r)
  );

  typedef struct packed {
    logic        ce_l, we_l; logic [5:0] a_l; logic [15:0] d_l;
    logic        ce_r, we_r; logic [5:0] a_r; logic [15:0] d_r;
    logic        xb_l, xb_r;
    logic        ck_l; logic [15:0] xr_l;
    logic        ck_r; logic [15:0] xr_r;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1,1,6'd5,16'h1111, 0,0,6'd0,16'h0,    1,1, 0,16'h0,    0,16'h0},    // 0
    '{1,1,6'd5,16'h2222, 1,1,6'd5,16'h3333, 1,0, 1,16'h1111, 1,16'h1111}, // 1 R3 R5
    '{0,0,6'd0,16'h0,    1,1,6'd5,16'h4444, 1,0, 0,16'h0,    1,16'h2222}, // 2 R4
    '{0,0,6'd0,16'h0,    1,1,6'd5,16'h4444, 1,1, 0,16'h0,    1,16'h2222}, // 3 R6
    '{0,0,6'd0,16'h0,    1,1,6'd5,16'h4444, 1,1, 0,16'h0,    1,16'h2222}, // 4
    '{0,0,6'd0,16'h0,    1,1,6'd5,16'h4444, 1,1, 0,16'h0,    1,16'h2222}, // 5 write lands
    '{0,0,6'd0,16'h0,    0,0,6'd0,16'h0,    1,1, 0,16'h0,    0,16'h0},    // 6
    '{1,0,6'd9,16'h0,    1,1,6'd9,16'h5555, 1,0, 1,16'h0,    1,16'h0},    // 7 R2 tie
    '{0,0,6'd0,16'h0,    0,0,6'd0,16'h0,    1,0, 0,16'h0,    0,16'h0},    // 8 R4
    '{0,0,6'd0,16'h0,    0,0,6'd0,16'h0,    1,1, 0,16'h0,    0,16'h0},    // 9
    '{0,0,6'd0,16'h0,    0,0,6'd0,16'h0,    1,1, 0,16'h0,    0,16'h0},    // 10
    '{0,0,6'd0,16'h0,    0,0,6'd0,16'h0,    1,1, 0,16'h0,    0,16'h0},    // 11
    '{0,0,6'd0,16'h0,    1,1,6'd3,16'h6666, 1,1, 0,16'h0,    1,16'h0},    // 12
    '{1,1,6'd3,16'h8888, 1,1,6'd3,16'h7777, 0,1, 1,16'h6666, 1,16'h6666}, // 13 R3 right wins
    '{1,1,6'd3,16'h9999, 1,0,6'd3,16'h0,    0,1, 1,16'h7777, 1,16'h7777}, // 14 R3 hold
    '{1,1,6'd3,16'h9999, 1,0,6'd4,16'h0,    0,1, 1,16'h7777, 1,16'h0},    // 15 R4
    '{1,1,6'd3,16'h9999, 0,0,6'd0,16'h0,    1,1, 1,16'h7777, 0,16'h0},    // 16 R6
    '{1,1,6'd3,16'h9999, 0,0,6'd0,16'h0,    1,1, 1,16'h7777, 0,16'h0},    // 17
    '{1,1,6'd3,16'h9999, 0,0,6'd0,16'h0,    1,1, 1,16'h7777, 0,16'h0},    // 18 R9 old data
    '{1,0,6'd1,16'h0,    1,0,6'd2,16'h0,    1,1, 1,16'h0,    1,16'h0},    // 19
    '{1,0,6'd1,16'h0,    1,1,6'd1,16'hBBBB, 1,0, 1,16'h0,    1,16'h0},    // 20 R1 addr match
    '{0,0,6'd0,16'h0,    0,0,6'd0,16'h0,    1,0, 0,16'h0,    0,16'h0},    // 21
    '{0,0,6'd0,16'h0,    0,0,6'd0,16'h0,    1,1, 0,16'h0,    0,16'h0}     // 22
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic cl, wl, input logic [5:0] al, input logic [15:0] dl,
                       input logic cr, wr, input logic [5:0] ar, input logic [15:0] dr);
    ce_l = cl; we_l = wl; addr_l = al; wd_l = dl;
    ce_r = cr; we_r = wr; addr_r = ar; wd_r = dr;
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; master = mode;
    drive(0,0,0,0,0,0,0,0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    // R8 reset state
    check("R8 busy_l", {15'd0, bout_l}, 16'd1);
    check("R8 busy_r", {15'd0, bout_r}, 16'd1);
    check("R8 rdata_l", rd_l, 16'h0);
    check("R8 rdata_r", rd_r, 16'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].ce_l, VEC[i].we_l, VEC[i].a_l, VEC[i].d_l,
            VEC[i].ce_r, VEC[i].we_r, VEC[i].a_r, VEC[i].d_r);
      #1;
      check($sformatf("R1/R2/R4 busy_l v%0d", i), {15'd0, bout_l}, {15'd0, VEC[i].xb_l});
      check($sformatf("R1/R2/R4 busy_r v%0d", i), {15'd0, bout_r}, {15'd0, VEC[i].xb_r});
      @(posedge clk); #1;
      if (VEC[i].ck_l) check($sformatf("R5/R9 rdata_l v%0d", i), rd_l, VEC[i].xr_l);
      if (VEC[i].ck_r) check($sformatf("R5/R9 rdata_r v%0d", i), rd_r, VEC[i].xr_r);
      @(negedge clk);
    end

    // memory contents after the table: R5 suppression, R6 late write
    drive(1,0,6'd5,0, 1,0,6'd3,0); @(posedge clk); #1;
    check("R6 mem[5] right late write", rd_l, 16'h4444);
    check("R6 mem[3] left late write", rd_r, 16'h9999);
    @(negedge clk);
    drive(1,0,6'd9,0, 0,0,0,0); @(posedge clk); #1;
    check("R5 mem[9] blocked write", rd_l, 16'h0);
    // R9 hold while ce low
    @(negedge clk);
    drive(0,0,6'd5,0, 1,0,6'd1,0); @(posedge clk); #1;
    check("R9 rdata_l holds", rd_l, 16'h0);
    check("R5 mem[1] blocked write", rd_r, 16'h0);
    @(negedge clk);

    // slave mode
    do_reset(1'b0);
    check("R8 mem cleared", rd_l, 16'h0);
    bin_r = 1'b0; drive(0,0,0,0, 1,1,6'd10,16'hA000); #1;
    check("R7 busy_r_no quiet", {15'd0, bout_r}, 16'd1);
    @(negedge clk);
    bin_r = 1'b1; drive(0,0,0,0, 1,1,6'd11,16'hA001); @(negedge clk);
    drive(0,0,0,0, 1,1,6'd12,16'hA002); @(negedge clk);
    drive(0,0,0,0, 1,1,6'd13,16'hA003); @(negedge clk);
    drive(1,0,6'd20,0, 1,0,6'd20,0); #1;
    check("R7 busy_l_no quiet on collision", {15'd0, bout_l}, 16'd1);
    check("R7 busy_r_no quiet on collision", {15'd0, bout_r}, 16'd1);
    @(negedge clk);
    drive(1,0,6'd10,0, 1,0,6'd11,0); @(posedge clk); #1;
    check("R7 ext busy blocks write", rd_l, 16'h0);
    check("R7 hold after ext release", rd_r, 16'h0);
    @(negedge clk);
    drive(1,0,6'd12,0, 1,0,6'd13,0); @(posedge clk); #1;
    check("R7 hold second cycle", rd_l, 16'h0);
    check("R7 write after hold", rd_r, 16'hA003);
    @(negedge clk);
    drive(0,0,0,0,0,0,0,0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule